// File: doc/BRIEF.md
# Carrier Acquisition Sequencer

This block supervises how a carrier recovery loop acquires a signal once the symbol timing loop reports lock. It walks through idle, equalizer warm-up, frequency offset estimation, two pull-in stages and final lock. At each step it tells the equalizer which adaptation rule to use and tells the loop filter which bandwidth to apply. It also holds the phase error at zero during the early stages. The equalizer, the frequency estimator and the loop filter are outside the block. They report back through pulses: pull-in success, pull-in failure and estimate ready.

There are two ways to find the frequency offset, chosen by a static select. In the first, the sequencer waits for a programmable number of estimates from the automatic frequency control arithmetic. In the second, it runs an 8-bit scan counter that moves one step to a new trial offset each time a pull-in attempt fails. All decisions are taken on output-symbol strobes, so status changes at most once per symbol.

Top module: `carrier_acq_seq`

## Requirements
- R1: A clock edge with `restart` high sets status to 000, `lock` to 0, `eq_mode` to 00, `pe_zero` to 1, `lf_track` to 0 and both counters to 0, whatever the other inputs are.
- R2: Apart from restart, the state, status, counters and all other outputs change only on edges where `sym_stb` is 1; on any other edge, inputs are ignored.
- R3: Idle (000) moves to the initial stage (001) on a strobe with `tlock` high and otherwise stays idle.
- R4: The initial stage lasts INIT_SHORT strobes when `init_sel`=0 and INIT_LONG strobes when `init_sel`=1. It then moves to AFC (010) if `afc_en`=1, or to scan (011) if `afc_en`=0.
- R5: In AFC, `afc_cnt` counts strobes that carry `afc_done`. After AFC_SHORT such strobes (`afc_avg_sel`=0) or AFC_LONG (`afc_avg_sel`=1), the state moves to fourth-power pull-in (100) and `afc_cnt` returns to 0.
- R6: The scan state lasts exactly one strobe and then moves to fourth-power pull-in (100).
- R7: In fourth-power pull-in, `pullin_fail` returns to AFC (if `afc_en`) or scan. Otherwise `pullin_ok` moves on to decision-directed pull-in (110). Failure wins when both are high.
- R8: In decision-directed pull-in, failure returns as in R7 and success moves to lock (111). Lock is left only through R1 or R10; pull-in pulses have no effect in lock.
- R9: With `afc_en`=0, each failure that returns to scan adds 1 to `scan_cnt`, wrapping from 255 to 0. Only restart clears it; loss of timing lock keeps its value.
- R10: A strobe with `tlock` low in any non-idle state returns the sequencer to idle.
- R11: Status codes are the ones above (101 never occurs). `lock` is 1 only in 111. `eq_mode` is 00 (hold) in idle, 10 (decision-directed) in lock, and 01 (CMA) otherwise. `pe_zero` is 1 only in idle and initial.
- R12: `lf_track` is 1 only in lock. `lf_wide` equals `track_bw_sel` in lock and `pull_bw_sel` in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| restart | input | 1 | Synchronous restart, active high |
| sym_stb | input | 1 | Output-symbol strobe, one cycle in two |
| tlock | input | 1 | Symbol timing loop lock flag |
| pullin_ok | input | 1 | Pull-in stage succeeded |
| pullin_fail | input | 1 | Pull-in stage failed |
| afc_done | input | 1 | One frequency estimate finished |
| init_sel | input | 1 | Initial stage length select (static) |
| afc_en | input | 1 | 1: use AFC estimation, 0: use scan counter (static) |
| afc_avg_sel | input | 1 | Number of estimates to average select (static) |
| pull_bw_sel | input | 1 | Wide bandwidth during acquisition (static) |
| track_bw_sel | input | 1 | Wide bandwidth during tracking (static) |
| status | output | 3 | Acquisition stage code |
| lock | output | 1 | Carrier loop locked |
| eq_mode | output | 2 | Equalizer rule: 00 hold, 01 CMA, 10 decision-directed |
| pe_zero | output | 1 | Force phase error to zero |
| scan_cnt | output | 8 | Frequency scan index |
| afc_cnt | output | AFC_CW | Estimates gathered in the current AFC pass |
| lf_track | output | 1 | Loop filter in tracking mode |
| lf_wide | output | 1 | Loop filter wide bandwidth select |

## Verification
The bench runs four kinds of stimulus. Directed walks through the AFC path measure how long the initial and AFC stages last for both length selects, which distinguishes off-by-one errors in the dwell limits. A scan run with failure held high forces more than 256 failures, which exposes wrong wrap behaviour and failure steps counted twice. Held-off strobes and simultaneous success and failure separate strobe gating from the pull-in priority. Segments of random stimulus, with occasional timing-loss and restart events, are compared on every clock against a behavioural model that tracks both frequency paths.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'b000,
    ST_INIT   = 3'b001,
    ST_AFC    = 3'b010,
    ST_SCAN   = 3'b011,
    ST_PULL4  = 3'b100,
    ST_PULLDD = 3'b110,
    ST_LOCK   = 3'b111
  } cas_state_e;

  typedef enum logic [1:0] {
    EQ_HOLD = 2'b00,
    EQ_CMA  = 2'b01,
    EQ_DD   = 2'b10
  } cas_eq_e;

  typedef struct packed {
    logic [2:0] status;
    logic       lock;
    logic [1:0] eq_mode;
    logic       pe_zero;
    logic       lf_track;
    logic       lf_wide;
  } cas_out_t;

  // Map a stage to the control word presented to the datapath.
  function automatic cas_out_t cas_decode(cas_state_e s, logic pull_wide, logic track_wide);
    cas_out_t o;
    o.status   = s;
    o.lock     = (s == ST_LOCK);
    o.lf_track = (s == ST_LOCK);
    o.lf_wide  = (s == ST_LOCK) ? track_wide : pull_wide;
    o.pe_zero  = (s == ST_IDLE) || (s == ST_INIT);
    case (s)
      ST_IDLE: o.eq_mode = EQ_HOLD;
      ST_LOCK: o.eq_mode = EQ_DD;
      default: o.eq_mode = EQ_CMA;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/cas_dwell_cnt.sv
// Dwell counter with terminal compare against a selectable limit.
module cas_dwell_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] lim,
  output logic          last,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == lim);
endmodule

// File: rtl/cas_scan_cnt.sv
// Trial frequency index; wraps naturally at its width.
module cas_scan_cnt #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          step,
  output logic [SW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (step)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cas_fsm.sv
// Stage sequencing; all decisions taken on symbol strobes only.
module cas_fsm
  import cas_pkg::*;
(
  input  logic       clk,
  input  logic       restart,
  input  logic       sym_stb,
  input  logic       tlock,
  input  logic       pullin_ok,
  input  logic       pullin_fail,
  input  logic       afc_done,
  input  logic       afc_en,
  input  logic       init_last,
  input  logic       afc_last,
  output cas_state_e state_q,
  output cas_state_e state_nxt,
  output logic       dwell_clr,
  output logic       init_inc,
  output logic       afc_inc,
  output logic       scan_step
);
  cas_state_e fail_dest;
  logic       fail_step;

  assign fail_dest = afc_en ? ST_AFC : ST_SCAN;

  always_comb begin
    state_nxt = state_q;
    fail_step = 1'b0;
    if (state_q != ST_IDLE && !tlock) begin
      state_nxt = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (tlock) state_nxt = ST_INIT;
        ST_INIT:  if (init_last) state_nxt = fail_dest;
        ST_AFC:   if (afc_done && afc_last) state_nxt = ST_PULL4;
        ST_SCAN:  state_nxt = ST_PULL4;
        ST_PULL4: begin
          if (pullin_fail) begin
            state_nxt = fail_dest;
            fail_step = !afc_en;
          end else if (pullin_ok) begin
            state_nxt = ST_PULLDD;
          end
        end
        ST_PULLDD: begin
          if (pullin_fail) begin
            state_nxt = fail_dest;
            fail_step = !afc_en;
          end else if (pullin_ok) begin
            state_nxt = ST_LOCK;
          end
        end
        default: state_nxt = state_q;
      endcase
    end
  end

  logic adv;
  assign adv       = sym_stb && !restart;
  assign dwell_clr = restart || (sym_stb && (state_nxt != state_q));
  assign init_inc  = adv && (state_q == ST_INIT) && (state_nxt == ST_INIT);
  assign afc_inc   = adv && (state_q == ST_AFC) && afc_done && (state_nxt == ST_AFC);
  assign scan_step = adv && fail_step;

  always_ff @(posedge clk) begin
    if (restart)
      state_q <= ST_IDLE;
    else if (sym_stb)
      state_q <= state_nxt;
  end
endmodule

// File: rtl/carrier_acq_seq.sv
module carrier_acq_seq
  import cas_pkg::*;
#(
  parameter int INIT_SHORT = 16384,
  parameter int INIT_LONG  = 32768,
  parameter int AFC_SHORT  = 16,
  parameter int AFC_LONG   = 64,
  parameter int SCAN_W     = 8,
  parameter int AFC_CW     = $clog2(AFC_LONG)
) (
  input  logic              clk,
  input  logic              restart,
  input  logic              sym_stb,
  input  logic              tlock,
  input  logic              pullin_ok,
  input  logic              pullin_fail,
  input  logic              afc_done,
  input  logic              init_sel,
  input  logic              afc_en,
  input  logic              afc_avg_sel,
  input  logic              pull_bw_sel,
  input  logic              track_bw_sel,
  output logic [2:0]        status,
  output logic              lock,
  output logic [1:0]        eq_mode,
  output logic              pe_zero,
  output logic [SCAN_W-1:0] scan_cnt,
  output logic [AFC_CW-1:0] afc_cnt,
  output logic              lf_track,
  output logic              lf_wide
);
  localparam int INIT_CW = $clog2(INIT_LONG);
  localparam logic [INIT_CW-1:0] INIT_LIM_S = INIT_CW'(INIT_SHORT - 1);
  localparam logic [INIT_CW-1:0] INIT_LIM_L = INIT_CW'(INIT_LONG - 1);
  localparam logic [AFC_CW-1:0]  AFC_LIM_S  = AFC_CW'(AFC_SHORT - 1);
  localparam logic [AFC_CW-1:0]  AFC_LIM_L  = AFC_CW'(AFC_LONG - 1);

  cas_state_e state_q, state_nxt;
  logic dwell_clr, init_inc, afc_inc, scan_step;
  logic init_last, afc_last;
  logic [INIT_CW-1:0] init_cnt;
  cas_out_t out_q;

  cas_fsm u_fsm (
    .clk         (clk),
    .restart     (restart),
    .sym_stb     (sym_stb),
    .tlock       (tlock),
    .pullin_ok   (pullin_ok),
    .pullin_fail (pullin_fail),
    .afc_done    (afc_done),
    .afc_en      (afc_en),
    .init_last   (init_last),
    .afc_last    (afc_last),
    .state_q     (state_q),
    .state_nxt   (state_nxt),
    .dwell_clr   (dwell_clr),
    .init_inc    (init_inc),
    .afc_inc     (afc_inc),
    .scan_step   (scan_step)
  );

  cas_dwell_cnt #(.CW(INIT_CW)) u_init_cnt (
    .clk  (clk),
    .clr  (dwell_clr),
    .inc  (init_inc),
    .lim  (init_sel ? INIT_LIM_L : INIT_LIM_S),
    .last (init_last),
    .cnt  (init_cnt)
  );

  cas_dwell_cnt #(.CW(AFC_CW)) u_afc_cnt (
    .clk  (clk),
    .clr  (dwell_clr),
    .inc  (afc_inc),
    .lim  (afc_avg_sel ? AFC_LIM_L : AFC_LIM_S),
    .last (afc_last),
    .cnt  (afc_cnt)
  );

  cas_scan_cnt #(.SW(SCAN_W)) u_scan_cnt (
    .clk  (clk),
    .clr  (restart),
    .step (scan_step),
    .cnt  (scan_cnt)
  );

  // Registered control word, loaded with the stage being entered.
  always_ff @(posedge clk) begin
    if (restart)
      out_q <= cas_decode(ST_IDLE, pull_bw_sel, track_bw_sel);
    else if (sym_stb)
      out_q <= cas_decode(state_nxt, pull_bw_sel, track_bw_sel);
  end

  assign status   = out_q.status;
  assign lock     = out_q.lock;
  assign eq_mode  = out_q.eq_mode;
  assign pe_zero  = out_q.pe_zero;
  assign lf_track = out_q.lf_track;
  assign lf_wide  = out_q.lf_wide;
endmodule

// File: rtl/cas_checker.sv
module cas_checker (
  input logic       clk,
  input logic       restart,
  input logic       sym_stb,
  input logic       tlock,
  input logic [2:0] status,
  input logic       lock,
  input logic [1:0] eq_mode,
  input logic       pe_zero,
  input logic [7:0] scan_cnt
);
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (restart) armed <= 1'b1;
  end

  assert_restart_idle_R1: assert property (@(posedge clk) disable iff (!armed)
    $past(restart) |-> (status == 3'b000 && scan_cnt == 8'd0 && pe_zero && !lock));

  assert_hold_off_strobe_R2: assert property (@(posedge clk) disable iff (restart || !armed)
    $past(!sym_stb && !restart) |-> (status == $past(status) && scan_cnt == $past(scan_cnt)));

  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (restart || !armed)
    ($past(status) == 3'b000 && status != 3'b000) |-> ($past(tlock) && status == 3'b001));

  assert_scan_step_R9: assert property (@(posedge clk) disable iff (restart || !armed)
    ($past(!restart) && scan_cnt != $past(scan_cnt)) |-> (status == 3'b011 && scan_cnt == $past(scan_cnt) + 8'd1));

  assert_tlock_loss_R10: assert property (@(posedge clk) disable iff (restart || !armed)
    $past(sym_stb && !tlock && !restart) |-> status == 3'b000);

  assert_dd_only_in_lock_R11: assert property (@(posedge clk) disable iff (restart || !armed)
    (eq_mode == 2'b10) == lock);

  assert_pe_zero_early_R11: assert property (@(posedge clk) disable iff (restart || !armed)
    pe_zero |-> (status[2:1] == 2'b00));

  assert_no_unused_code_R11: assert property (@(posedge clk) disable iff (restart || !armed)
    status != 3'b101);
endmodule

bind carrier_acq_seq cas_checker chk_i (
  .clk      (clk),
  .restart  (restart),
  .sym_stb  (sym_stb),
  .tlock    (tlock),
  .status   (status),
  .lock     (lock),
  .eq_mode  (eq_mode),
  .pe_zero  (pe_zero),
  .scan_cnt (scan_cnt)
);

// File: tb/carrier_acq_seq_tb.sv
module carrier_acq_seq_tb_top;
  localparam int IS  = 5;
  localparam int IL  = 9;
  localparam int AS  = 3;
  localparam int AL  = 5;
  localparam int ACW = $clog2(AL);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic restart = 1'b1, sym_stb = 1'b0, tlock = 1'b0;
  logic pullin_ok = 1'b0, pullin_fail = 1'b0, afc_done = 1'b0;
  logic init_sel = 1'b0, afc_en = 1'b1, afc_avg_sel = 1'b0;
  logic pull_bw_sel = 1'b0, track_bw_sel = 1'b1;

  logic [2:0]     status;
  logic           lock, pe_zero, lf_track, lf_wide;
  logic [1:0]     eq_mode;
  logic [7:0]     scan_cnt;
  logic [ACW-1:0] afc_cnt;

  carrier_acq_seq #(
    .INIT_SHORT(IS), .INIT_LONG(IL), .AFC_SHORT(AS), .AFC_LONG(AL),
    .SCAN_W(8), .AFC_CW(ACW)
  ) dut_i (
    .clk(clk), .restart(restart), .sym_stb(sym_stb), .tlock(tlock),
    .pullin_ok(pullin_ok), .pullin_fail(pullin_fail), .afc_done(afc_done),
    .init_sel(init_sel), .afc_en(afc_en), .afc_avg_sel(afc_avg_sel),
    .pull_bw_sel(pull_bw_sel), .track_bw_sel(track_bw_sel),
    .status(status), .lock(lock), .eq_mode(eq_mode), .pe_zero(pe_zero),
    .scan_cnt(scan_cnt), .afc_cnt(afc_cnt), .lf_track(lf_track), .lf_wide(lf_wide)
  );

  int    total = 0, bad = 0;
  string ph = "R1";
  bit    cmp_on = 1'b0, stb_run = 1'b0, done = 1'b0;

  // behavioural reference
  int m_st = 0, m_ic = 0, m_ac = 0, m_sc = 0, m_wide = 0;

  always @(negedge clk) begin
    if (stb_run) sym_stb <= ~sym_stb;
    else         sym_stb <= 1'b0;
  end

  always @(posedge clk) begin
    if (restart) begin
      m_st = 0; m_ic = 0; m_ac = 0; m_sc = 0; m_wide = pull_bw_sel;
    end else if (sym_stb) begin
      if (m_st != 0 && !tlock) begin
        m_st = 0; m_ic = 0; m_ac = 0;
      end else begin
        case (m_st)
          0: if (tlock) m_st = 1;
          1: if (m_ic == (init_sel ? IL : IS) - 1) begin
               m_ic = 0; m_st = afc_en ? 2 : 3;
             end else m_ic++;
          2: if (afc_done) begin
               if (m_ac == (afc_avg_sel ? AL : AS) - 1) begin m_ac = 0; m_st = 4; end
               else m_ac++;
             end
          3: m_st = 4;
          4, 6: if (pullin_fail) begin
               if (afc_en) m_st = 2;
               else begin m_st = 3; m_sc = (m_sc + 1) % 256; end
             end else if (pullin_ok) m_st = (m_st == 4) ? 6 : 7;
          default: ;
        endcase
      end
      m_wide = (m_st == 7) ? track_bw_sel : pull_bw_sel;
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(ph, "status", int'(status), m_st);
      chk(ph, "lock", int'(lock), int'(m_st == 7));
      chk(ph, "eq_mode", int'(eq_mode), (m_st == 0) ? 0 : (m_st == 7) ? 2 : 1);
      chk(ph, "pe_zero", int'(pe_zero), int'(m_st <= 1));
      chk(ph, "scan_cnt", int'(scan_cnt), m_sc);
      chk(ph, "afc_cnt", int'(afc_cnt), m_ac);
      chk(ph, "lf_track", int'(lf_track), int'(m_st == 7));
      chk(ph, "lf_wide", int'(lf_wide), m_wide);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_status(int s, int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (int'(status) == s) return;
      @(negedge clk);
    end
  endtask

  // counts cycles spent in stage s, starting once it is seen
  task automatic dwell(int s, output int n);
    n = 0;
    wait_status(s, 200);
    for (int i = 0; i < 400; i++) begin
      if (int'(status) != s) return;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int keep;
    cyc(1);
    stb_run = 1'b1;
    cyc(2);
    cmp_on = 1'b1;
    chk("R1", "status after restart", int'(status), 0);
    chk("R1", "pe_zero after restart", int'(pe_zero), 1);
    chk("R1", "eq_mode after restart", int'(eq_mode), 0);
    restart = 1'b0;

    ph = "R3";
    cyc(20);
    chk("R3", "idle without tlock", int'(status), 0);
    tlock = 1'b1;

    ph = "R4";
    dwell(1, n);
    chk("R4", "initial dwell cycles short", n, 2 * IS);
    chk("R4", "stage after initial", int'(status), 2);

    ph = "R5";
    afc_done = 1'b1;
    dwell(2, n);
    chk("R5", "afc dwell cycles short", n, 2 * AS);
    chk("R5", "stage after afc", int'(status), 4);

    ph = "R7";
    pullin_ok = 1'b1; pullin_fail = 1'b1;
    cyc(2);
    chk("R7", "fail wins over ok", int'(status), 2);
    pullin_fail = 1'b0;

    ph = "R8";
    cyc(40);
    chk("R8", "reached lock", int'(status), 7);
    chk("R11", "dd mode in lock", int'(eq_mode), 2);
    chk("R12", "tracking bandwidth", int'(lf_wide), 1);
    pullin_fail = 1'b1;
    cyc(10);
    chk("R8", "lock ignores fail", int'(status), 7);
    pullin_fail = 1'b0; pullin_ok = 1'b0;

    ph = "R2";
    stb_run = 1'b0;
    cyc(2);
    tlock = 1'b0;
    cyc(6);
    chk("R2", "no strobe keeps lock", int'(status), 7);
    tlock = 1'b1; stb_run = 1'b1;
    cyc(2);

    ph = "R10";
    tlock = 1'b0;
    cyc(4);
    chk("R10", "tlock loss to idle", int'(status), 0);

    // long initial and long averaging
    ph = "R4";
    restart = 1'b1; init_sel = 1'b1; afc_avg_sel = 1'b1;
    cyc(2);
    restart = 1'b0; tlock = 1'b1;
    dwell(1, n);
    chk("R4", "initial dwell cycles long", n, 2 * IL);
    ph = "R5";
    dwell(2, n);
    chk("R5", "afc dwell cycles long", n, 2 * AL);

    // scan path with wrap
    ph = "R9";
    restart = 1'b1; afc_en = 1'b0; init_sel = 1'b0;
    cyc(2);
    restart = 1'b0;
    dwell(1, n);
    chk("R4", "scan entered after initial", int'(status), 3);
    ph = "R6";
    dwell(3, n);
    chk("R6", "scan dwell one strobe", n, 2);
    ph = "R9";
    pullin_fail = 1'b1;
    cyc(1100);
    chk("R9", "scan wrapped count", int'(scan_cnt), m_sc);
    pullin_fail = 1'b0;
    keep = int'(scan_cnt);
    tlock = 1'b0;
    cyc(4);
    chk("R9", "scan kept on tlock loss", int'(scan_cnt), keep);
    chk("R10", "idle after tlock loss", int'(status), 0);

    // random segments
    for (int seg = 0; seg < 4; seg++) begin
      ph = "R7/R8/R10";
      restart = 1'b1;
      afc_en = seg[0]; afc_avg_sel = seg[1]; init_sel = ~seg[0];
      pull_bw_sel = seg[1]; track_bw_sel = ~seg[1];
      cyc(2);
      restart = 1'b0;
      for (int i = 0; i < 1500; i++) begin
        tlock       = ($urandom % 64) != 0;
        pullin_ok   = ($urandom % 4) == 0;
        pullin_fail = ($urandom % 5) == 0;
        afc_done    = ($urandom % 2) == 0;
        stb_run     = ($urandom % 16) != 0;
        restart     = ($urandom % 500) == 0;
        cyc(1);
      end
      stb_run = 1'b1; restart = 1'b0;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired, R1 flow hung got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule